// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This controller connects a simple single-bit host request port to a DRAM that stores one bit per location and takes its location address over a shared, narrow address bus. The host gives a full 20-bit location address, a write flag and a write bit. The controller splits the address into a row half and a column half and sends them one after the other on the 10-bit bus. The row half goes out under an active-low row strobe. The column half goes out under an active-low column strobe. During the column phase the controller drives the active-low write line, presents the write bit on a dedicated data-in line, or samples the read bit from a dedicated data-out line. It then signals completion with a one-cycle done pulse and the read bit.

A refresh engine keeps the DRAM contents alive. A tick timer marks one row as due every `REF_TICK` cycles, and a row counter walks through all 1024 rows. A due refresh runs as a row-strobe-only cycle whenever the host port is quiet. When the host keeps the port busy, host requests win until the pending refresh has waited `REF_LATE` cycles. After that the refresh takes the next free slot and the port stops accepting requests until the refresh has started. Each strobe phase lasts `STROBE_CYC` cycles. Both strobes stay high for `PRE_CYC` cycles after every access or refresh.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While rst_ni is low, and right after its release, ras_no and cas_no are high (inactive), done_o is low and ready_o is high.
- R2: An accepted request first drives ras_no low for exactly STROBE_CYC cycles with dram_addr_o equal to addr_i[19:10], the row half. The bus holds steady throughout.
- R3: In the cycle after the row phase ends, ras_no is high and cas_no goes low for exactly STROBE_CYC cycles with dram_addr_o equal to addr_i[9:0], the column half. The two strobes are never low together.
- R4: we_i=1 selects a write: we_no is low during the column phase and din_o carries wdata_i. we_i=0 selects a read: we_no stays high. we_no is never low outside the column phase.
- R5: After every access or refresh, both strobes stay high for at least PRE_CYC cycles before ras_no falls again.
- R6: done_o is high for exactly one cycle, in the cycle after the column phase. For a read, rdata_o then holds the bit the DRAM returned, which is the bit last written to that location.
- R7: A request is accepted at a clock edge where req_i and ready_o are both high. ready_o is high only while the controller is idle with no overdue refresh, so it is low for the whole of an access.
- R8: With the host idle, a refresh cycle (ras_no low with the row counter on the bus, cas_no high) starts exactly every REF_TICK cycles. The refreshed row steps up by one each time and wraps from 1023 to 0.
- R9: When a refresh becomes due in the same cycle that a request is waiting and the refresh is not yet overdue, the host access is served first and the refresh follows it.
- R10: When back-to-back requests keep the port busy, a due refresh starts between REF_LATE+1 and REF_LATE+7 cycles after it became due (with the bench's 2-cycle strobes and precharge). Data written in that traffic reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Location address, row in [19:10], column in [9:0] |
| wdata_i | input | 1 | Write bit |
| ready_o | output | 1 | Controller can accept a request this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 1 | Read bit, valid with done_o |
| dram_addr_o | output | 10 | Multiplexed row/column address bus |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write line, active low |
| din_o | output | 1 | Bit written into the DRAM |
| dout_i | input | 1 | Bit read from the DRAM |

## Verification
The bench goes after the arbitration corners. A refresh that becomes due in the very cycle a request waits must not push the host aside; a design that gives refresh plain priority starts a row-only cycle first and delays the access. Under saturated traffic the refresh must wait, yet not past its lateness window; a design that never raises priority starves the refresh, and one that ignores the limit refreshes too early. The row counter is run through its wrap, where a wrong counter width repeats or skips rows. Reads after dense writes interleaved with refreshes catch a refresh that clobbers the latched access address, since the data would then land in the wrong row.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_REF,
    ST_PRE
  } phase_e;
endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W    = 10,
  parameter int TICK_CYC = 240,
  parameter int LATE_CYC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  output logic             pend_o,
  output logic             urgent_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int TW = $clog2(TICK_CYC + 1);
  localparam int LW = $clog2(LATE_CYC + 1);

  logic [TW-1:0]    tick_q;
  logic [LW-1:0]    wait_q;
  logic [ROW_W-1:0] row_q;
  logic             pend_q;
  logic             tick;

  assign tick = (tick_q == TW'(TICK_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      pend_q <= 1'b0;
      wait_q <= '0;
      row_q  <= '0;
    end else begin
      tick_q <= tick ? '0 : tick_q + 1'b1;
      if (tick)       pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
      // lateness counter saturates at the limit
      if (ack_i || !pend_q)             wait_q <= '0;
      else if (wait_q != LW'(LATE_CYC)) wait_q <= wait_q + 1'b1;
      if (ack_i) row_q <= row_q + 1'b1;
    end
  end

  assign pend_o   = pend_q;
  assign urgent_o = pend_q && (wait_q == LW'(LATE_CYC));
  assign row_o    = row_q;
endmodule

// File: rtl/dram_access_fsm.sv
module dram_access_fsm
  import dram_mux_pkg::*;
#(
  parameter int ROW_W      = 10,
  parameter int STROBE_CYC = 2,
  parameter int PRE_CYC    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [2*ROW_W-1:0] addr_i,
  input  logic               wdata_i,
  input  logic               ref_pend_i,
  input  logic               ref_urgent_i,
  input  logic [ROW_W-1:0]   ref_row_i,
  output logic               ref_ack_o,
  output logic               ready_o,
  output logic               done_o,
  output logic               rdata_o,
  output logic [ROW_W-1:0]   dram_addr_o,
  output logic               ras_no,
  output logic               cas_no,
  output logic               we_no,
  output logic               din_o,
  input  logic               dout_i
);
  localparam int ADDR_W = 2 * ROW_W;
  localparam int MAXC   = (STROBE_CYC > PRE_CYC) ? STROBE_CYC : PRE_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  phase_e            st_q, st_d;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q, wd_q, done_q, rd_q;
  logic              last, hold_ref, take_ref, accept, col_end;

  assign hold_ref  = ref_pend_i && ref_urgent_i;
  assign ready_o   = (st_q == ST_IDLE) && !hold_ref;
  // host wins a tie unless the refresh is overdue
  assign take_ref  = (st_q == ST_IDLE) && ref_pend_i && (ref_urgent_i || !req_i);
  assign accept    = ready_o && req_i;
  assign ref_ack_o = take_ref;
  assign last      = (st_q == ST_PRE) ? (cnt_q == CW'(PRE_CYC - 1))
                                      : (cnt_q == CW'(STROBE_CYC - 1));
  assign col_end   = (st_q == ST_COL) && last;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (take_ref)    st_d = ST_REF;
        else if (accept) st_d = ST_ROW;
      end
      ST_ROW:  if (last) st_d = ST_COL;
      ST_COL:  if (last) st_d = ST_PRE;
      ST_REF:  if (last) st_d = ST_PRE;
      ST_PRE:  if (last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      wr_q   <= 1'b0;
      wd_q   <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_d != st_q) ? '0 : cnt_q + 1'b1;
      if (accept) begin
        addr_q <= addr_i;
        wr_q   <= we_i;
        wd_q   <= wdata_i;
      end else if (take_ref) begin
        addr_q[ADDR_W-1:ROW_W] <= ref_row_i;
      end
      done_q <= col_end;
      if (col_end && !wr_q) rd_q <= dout_i;
    end
  end

  assign ras_no      = !((st_q == ST_ROW) || (st_q == ST_REF));
  assign cas_no      = (st_q != ST_COL);
  assign we_no       = !((st_q == ST_COL) && wr_q);
  assign din_o       = wd_q;
  assign dram_addr_o = (st_q == ST_COL) ? addr_q[ROW_W-1:0] : addr_q[ADDR_W-1:ROW_W];
  assign done_o      = done_q;
  assign rdata_o     = rd_q;
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ROW_W      = 10,
  parameter int STROBE_CYC = 2,
  parameter int PRE_CYC    = 2,
  parameter int REF_TICK   = 240,
  parameter int REF_LATE   = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [2*ROW_W-1:0]   addr_i,
  input  logic                 wdata_i,
  output logic                 ready_o,
  output logic                 done_o,
  output logic                 rdata_o,
  output logic [ROW_W-1:0]     dram_addr_o,
  output logic                 ras_no,
  output logic                 cas_no,
  output logic                 we_no,
  output logic                 din_o,
  input  logic                 dout_i
);
  logic             ref_pend, ref_urgent, ref_ack;
  logic [ROW_W-1:0] ref_row;

  dram_refresh_sched #(
    .ROW_W   (ROW_W),
    .TICK_CYC(REF_TICK),
    .LATE_CYC(REF_LATE)
  ) u_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ack_i   (ref_ack),
    .pend_o  (ref_pend),
    .urgent_o(ref_urgent),
    .row_o   (ref_row)
  );

  dram_access_fsm #(
    .ROW_W     (ROW_W),
    .STROBE_CYC(STROBE_CYC),
    .PRE_CYC   (PRE_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .ref_pend_i  (ref_pend),
    .ref_urgent_i(ref_urgent),
    .ref_row_i   (ref_row),
    .ref_ack_o   (ref_ack),
    .ready_o     (ready_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o),
    .dram_addr_o (dram_addr_o),
    .ras_no      (ras_no),
    .cas_no      (cas_no),
    .we_no       (we_no),
    .din_o       (din_o),
    .dout_i      (dout_i)
  );
endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
  parameter int ROW_W      = 10,
  parameter int STROBE_CYC = 2,
  parameter int PRE_CYC    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_o,
  input logic             done_o,
  input logic             ras_no,
  input logic             cas_no,
  input logic             we_no,
  input logic [ROW_W-1:0] dram_addr_o
);
  localparam int CW = $clog2(STROBE_CYC + PRE_CYC + 2) + 1;

  logic [CW-1:0] ras_run, cas_run, gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_run <= '0;
      cas_run <= '0;
      gap_q   <= CW'(PRE_CYC);
    end else begin
      if (!ras_no) ras_run <= (ras_run == '1) ? ras_run : ras_run + 1'b1;
      else         ras_run <= '0;
      if (!cas_no) cas_run <= (cas_run == '1) ? cas_run : cas_run + 1'b1;
      else         cas_run <= '0;
      if (ras_no && cas_no) gap_q <= (gap_q == '1) ? gap_q : gap_q + 1'b1;
      else                  gap_q <= '0;
    end
  end

  assert_row_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no) |-> ras_run == CW'(STROBE_CYC));
  assert_row_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_no && $past(!ras_no)) |-> $stable(dram_addr_o));
  assert_col_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_no) |-> cas_run == CW'(STROBE_CYC));
  assert_col_after_row_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> $rose(ras_no));
  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ras_no && !cas_no));
  assert_we_in_col_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !cas_no);
  assert_precharge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> gap_q >= CW'(PRE_CYC));
  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_ready_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ras_no && cas_no));
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(
  .ROW_W     (ROW_W),
  .STROBE_CYC(STROBE_CYC),
  .PRE_CYC   (PRE_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .done_o     (done_o),
  .ras_no     (ras_no),
  .cas_no     (cas_no),
  .we_no      (we_no),
  .dram_addr_o(dram_addr_o)
);

// File: tb/dram_mux_ctrl_bench.sv
module dram_mux_ctrl_bench;
  localparam int ROW_W = 10;
  localparam int S     = 2;
  localparam int P     = 2;
  localparam int TICK  = 40;
  localparam int LATE  = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, wdata_i = 1'b0;
  logic [2*ROW_W-1:0] addr_i = '0;
  logic ready_o, done_o, rdata_o, ras_no, cas_no, we_no, din_o;
  logic dout_i = 1'b0;
  logic [ROW_W-1:0] dram_addr_o;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 1'b0;

  dram_mux_ctrl #(.ROW_W(ROW_W), .STROBE_CYC(S), .PRE_CYC(P),
                  .REF_TICK(TICK), .REF_LATE(LATE)) u_dram_mux_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ready_o(ready_o), .done_o(done_o), .rdata_o(rdata_o),
    .dram_addr_o(dram_addr_o), .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no),
    .din_o(din_o), .dout_i(dout_i));

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // DRAM model: one bit per location
  bit mem [int];
  logic [ROW_W-1:0] row_lat = '0;
  always @(posedge clk_i) begin
    if (!ras_no) row_lat <= dram_addr_o;
    if (!cas_no) begin
      if (!we_no) mem[int'({row_lat, dram_addr_o})] = din_o;
      dout_i <= mem.exists(int'({row_lat, dram_addr_o})) ? mem[int'({row_lat, dram_addr_o})] : 1'b0;
    end
  end

  // bus monitor
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int cur_start, ras_len, cas_len, gap = 100;
  int len_err = 0, gap_err = 0, seq_err = 0, order_err = 0;
  int ref_cnt = 0, last_ref_start = 0, prev_ref_start = 0, host_start = 0, ph = 0;
  int late_ok = 0, late_bad = 0;
  bit sat_mode = 1'b0, wrap_seen = 1'b0;
  logic [ROW_W-1:0] cur_row, host_row, last_ref_row, col_addr;
  logic col_we, col_din;

  always @(negedge clk_i) if (rst_ni) begin
    if (!ras_no && prev_ras) begin
      cur_start = cyc; cur_row = dram_addr_o; ras_len = 0;
      if (gap < P) gap_err++;
    end
    if (!ras_no) ras_len++;
    if (ras_no && !prev_ras) begin
      if (ras_len != S) len_err++;
      if (!cas_no) begin
        host_row = cur_row; host_start = cur_start;
      end else begin
        ref_cnt++;
        if (ref_cnt > 1 && cur_row != last_ref_row + 1'b1) seq_err++;
        if (ref_cnt > 1 && last_ref_row == '1 && cur_row == '0) wrap_seen = 1'b1;
        last_ref_row = cur_row;
        prev_ref_start = last_ref_start; last_ref_start = cur_start;
        if (sat_mode) begin
          int e0, d;
          e0 = ph + ((cur_start - 1 - ph) / TICK) * TICK;
          d = cur_start - e0;
          if (d >= LATE + 1 && d <= LATE + 7) late_ok++; else late_bad++;
        end
      end
    end
    if (!cas_no && prev_cas) begin
      col_addr = dram_addr_o; col_we = we_no; col_din = din_o; cas_len = 0;
      if (!(ras_no && !prev_ras)) order_err++;
    end
    if (!cas_no) cas_len++;
    if (cas_no && !prev_cas && cas_len != S) len_err++;
    if (ras_no && cas_no) gap++; else gap = 0;
    prev_ras = ras_no; prev_cas = cas_no;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one host access, called and returning at a negedge
  task automatic t_access(input logic wr, input logic [19:0] a, input logic wd, output logic rd);
    req_i = 1'b1; we_i = wr; addr_i = a; wdata_i = wd;
    while (!ready_o) @(negedge clk_i);
    @(negedge clk_i);
    check(ready_o == 1'b0, "R7 busy", ready_o, 0);
    req_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    rd = rdata_o;
    check(host_row == a[19:10], "R2 row half", host_row, a[19:10]);
    check(col_addr == a[9:0], "R3 col half", col_addr, a[9:0]);
    check(col_we == !wr, "R4 write line", col_we, !wr);
    if (wr) check(col_din == wd, "R4 din", col_din, wd);
    @(negedge clk_i);
    check(done_o == 1'b0, "R6 done width", done_o, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    check(ras_no && cas_no, "R1 strobes in reset", {ras_no, cas_no}, 3);
    check(done_o == 1'b0, "R1 done in reset", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(ready_o == 1'b1, "R1 ready after reset", ready_o, 1);
    check(ras_no && cas_no, "R1 strobes after reset", {ras_no, cas_no}, 3);
  endtask

  task automatic t_patterns();
    logic [19:0] al [5] = '{20'h00000, 20'hFFFFF, 20'h12345, 20'hABCDE, 20'h12344};
    logic dl [5] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    logic rd;
    for (int i = 0; i < 5; i++) t_access(1'b1, al[i], dl[i], rd);
    for (int i = 0; i < 5; i++) begin
      t_access(1'b0, al[i], 1'b0, rd);
      check(rd == dl[i], "R6 read data", rd, dl[i]);
    end
    t_access(1'b1, 20'h12345, 1'b1, rd);
    t_access(1'b1, 20'h12345, 1'b0, rd);
    t_access(1'b0, 20'h12345, 1'b0, rd);
    check(rd == 1'b0, "R6 overwrite", rd, 0);
  endtask

  task automatic t_idle_refresh();
    while (!(wrap_seen && ref_cnt > 3)) @(negedge clk_i);
    check(last_ref_start - prev_ref_start == TICK, "R8 period", last_ref_start - prev_ref_start, TICK);
    check(seq_err == 0, "R8 row sequence", seq_err, 0);
    check(wrap_seen, "R8 wrap", wrap_seen, 1);
    ph = last_ref_start - 1;
  endtask

  task automatic t_host_first();
    int t;
    logic rd;
    t = ph + TICK;
    while (t <= cyc + 2) t += TICK;
    while (cyc != t) @(negedge clk_i);
    check(ready_o == 1'b1, "R9 ready with refresh due", ready_o, 1);
    t_access(1'b1, 20'h3C0F1, 1'b1, rd);
    check(host_start == t + 1, "R9 host served first", host_start, t + 1);
    while (last_ref_start <= t) @(negedge clk_i);
    check(last_ref_start == t + 8, "R9 refresh follows host", last_ref_start, t + 8);
  endtask

  task automatic t_overdue();
    int r0;
    logic rd;
    r0 = ref_cnt;
    while (ref_cnt == r0) @(negedge clk_i);
    late_ok = 0; late_bad = 0; sat_mode = 1'b1;
    for (int i = 0; i < 60; i++) begin
      req_i = 1'b1; we_i = 1'b1;
      addr_i = 20'h40000 + 20'(i * 20'h0411);
      wdata_i = ^addr_i;
      while (!ready_o) @(negedge clk_i);
      @(negedge clk_i);
    end
    req_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
    sat_mode = 1'b0;
    check(late_ok >= 8, "R10 overdue refreshes", late_ok, 8);
    check(late_bad == 0, "R10 refresh window", late_bad, 0);
    for (int i = 0; i < 60; i += 7) begin
      logic [19:0] a;
      a = 20'h40000 + 20'(i * 20'h0411);
      t_access(1'b0, a, 1'b0, rd);
      check(rd == ^a, "R10 data intact", rd, ^a);
    end
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_idle_refresh();
    t_host_first();
    t_overdue();
    check(len_err == 0, "R2 R3 strobe length", len_err, 0);
    check(order_err == 0, "R3 column after row", order_err, 0);
    check(gap_err == 0, "R5 precharge gap", gap_err, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule